// File: doc/BRIEF.md
# SPI flash command engine

This block is a register-driven serial-flash command sequencer. It runs exactly one command at a time. Software places a command word in the opcode register and, if needed, a payload word in the data register. It then writes the control register with a transmit byte count, a receive byte count and the start bit. The engine drives a mode-0 SPI master port. It sends the transmit bytes and then clocks in the receive bytes, which it shifts into the data register.

The transmit stream is built from two registers. The opcode register gives the command byte and a 24-bit address. The data register gives up to four payload bytes. A single transfer can therefore carry a program command with its address and data, an erase with its address, or a status or signature query. Software polls the busy bit in the control register to learn when a command has finished. The SCK half period is set at build time in system clock cycles.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the control, opcode and data registers read 0, spi_cs_n is 1, and spi_sck and spi_mosi are 0.
- R2: The control register sits at byte offset 0x0, the opcode register at 0x4 and the data register at 0x8. Any other offset reads 0 and ignores writes. In the control word, every bit except 8 and 16 reads back the value last written. Bit 8 always reads 0. Bit 16 reads the busy state and is not affected by writes.
- R3: A control write made while idle starts a transaction when bit 8 is 1 and the transmit count in bits 3:0 is nonzero. From the next cycle, busy reads 1 and spi_cs_n is 0. A control write made while busy is ignored entirely, and this includes a new start.
- R4: A start with a transmit count of 0 does nothing on the SPI pins. spi_cs_n stays 1 and busy stays 0.
- R5: The transmit bytes go out in this order. Byte 0 is opcode[7:0]. Bytes 1, 2 and 3 are opcode[31:24], opcode[23:16] and opcode[15:8]. Bytes 4 to 7 are data[7:0], data[15:8], data[23:16] and data[31:24]. Any byte with index 8 or higher is 0x00. Each byte is sent MSB first, and spi_mosi never changes while spi_sck is high.
- R6: A transaction produces exactly 8*(tx+rx) spi_sck pulses, where rx is control bits 7:4.
- R7: The rx bytes follow the tx bytes, and spi_mosi is 0 during them. spi_miso is sampled on each rising edge of spi_sck. Each completed rx byte shifts the data register left by 8 bits and enters at bits 7:0.
- R8: spi_sck is 0 whenever spi_cs_n is 1. The first rising edge of spi_sck comes 2*SCK_HALF clock cycles after spi_cs_n falls.
- R9: Busy clears exactly one clock cycle after spi_cs_n rises. A control write that lands in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two events can land on the same clock edge: the end of a transaction and a new start request from software. There is a single cycle in which chip select has already been released but busy still reads 1. The bench waits for the rising edge of spi_cs_n and issues a start on the very next edge. It then confirms that busy was still set in that cycle, that the control word kept its previous counts, and that no further chip-select assertion follows. A start issued one cycle later is then shown to run normally.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int SCK_HALF = 2,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);

  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SCK_HALF - 1);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_OP  = AW'(4);
  localparam logic [AW-1:0] A_DAT = AW'(8);
  localparam logic [31:0] CTL_KEEP = ~32'h0001_0100;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER, S_END} st_t;

  st_t         st;
  logic [31:0] ctl_q, op_q, dat_q;
  logic [DW-1:0] div;
  logic        sck_q, cs_q;
  logic [2:0]  bit_q;
  logic [4:0]  byte_q;
  logic [7:0]  sh, rxb;

  logic busy;
  assign busy = (st != S_IDLE);

  logic wr, wr_ctl, wr_op, wr_dat, start;
  assign wr     = bus_en && bus_we;
  assign wr_ctl = wr && bus_addr == A_CTL && !busy;
  assign wr_op  = wr && bus_addr == A_OP;
  assign wr_dat = wr && bus_addr == A_DAT;
  assign start  = wr_ctl && bus_wdata[8] && (bus_wdata[3:0] != 4'd0);

  logic [3:0] tx_n, rx_n;
  logic [4:0] total;
  assign tx_n  = ctl_q[3:0];
  assign rx_n  = ctl_q[7:4];
  assign total = {1'b0, tx_n} + {1'b0, rx_n};

  function automatic logic [7:0] tx_byte(input logic [4:0] idx, input logic [3:0] n,
                                         input logic [31:0] op, input logic [31:0] dat);
    if (idx >= {1'b0, n}) return 8'h00;
    case (idx)
      5'd0: return op[7:0];
      5'd1: return op[31:24];
      5'd2: return op[23:16];
      5'd3: return op[15:8];
      5'd4: return dat[7:0];
      5'd5: return dat[15:8];
      5'd6: return dat[23:16];
      5'd7: return dat[31:24];
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ctl_q  <= '0;
      op_q   <= '0;
      dat_q  <= '0;
      div    <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      bit_q  <= '0;
      byte_q <= '0;
      sh     <= '0;
      rxb    <= '0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata & CTL_KEEP;
      if (wr_op)  op_q  <= bus_wdata;
      if (wr_dat) dat_q <= bus_wdata;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_LEAD;
          cs_q   <= 1'b0;
          div    <= '0;
          bit_q  <= '0;
          byte_q <= '0;
          sh     <= op_q[7:0];
        end
        S_LEAD: begin
          if (div == DIV_LAST) begin
            div <= '0;
            st  <= S_XFER;
          end else div <= div + 1'b1;
        end
        S_XFER: begin
          if (div != DIV_LAST) div <= div + 1'b1;
          else begin
            div <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rxb   <= {rxb[6:0], spi_miso};
            end else begin
              sck_q <= 1'b0;
              if (bit_q == 3'd7) begin
                bit_q <= '0;
                if (byte_q >= {1'b0, tx_n}) dat_q <= {dat_q[23:0], rxb};
                if (byte_q == total - 5'd1) begin
                  st   <= S_END;
                  cs_q <= 1'b1;
                  sh   <= '0;
                end else begin
                  byte_q <= byte_q + 5'd1;
                  sh     <= tx_byte(byte_q + 5'd1, tx_n, op_q, dat_q);
                end
              end else begin
                bit_q <= bit_q + 3'd1;
                sh    <= {sh[6:0], 1'b0};
              end
            end
          end
        end
        S_END: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = sh[7];

  assign bus_rdata = (bus_addr == A_CTL) ? (ctl_q | {15'd0, busy, 16'd0}) :
                     (bus_addr == A_OP)  ? op_q :
                     (bus_addr == A_DAT) ? dat_q : 32'h0;

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic busy
);

  assert_sck_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  assert_cs_within_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  assert_busy_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> busy);

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> !busy);

  assert_lead_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |=> !spi_sck);

endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .busy(busy)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
  localparam int SCK_HALF = 2;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  spi_cmd_engine #(.SCK_HALF(SCK_HALF), .AW(AW)) u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // flash-side model
  int nbits = 0, ncs = 0, cur_tx = 0;
  logic [31:0] cur_resp = '0;
  logic [7:0] cap [32];
  time t_cs = 0, lead = 0;

  function automatic logic miso_bit(int k, int tx, logic [31:0] resp);
    int b = k - 8 * tx;
    if (b >= 0 && b < 32) return resp[31 - b];
    return 1'b0;
  endfunction

  assign spi_miso = miso_bit(nbits, cur_tx, cur_resp);

  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (!spi_sck) begin
      nbits = 0; ncs++; t_cs = $time;
      for (int i = 0; i < 32; i++) cap[i] = 8'h00;
    end else begin
      if (nbits == 0) lead = $time - t_cs;
      if (nbits < 256) cap[nbits / 8] = {cap[nbits / 8][6:0], spi_mosi};
      nbits++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    int n = 0;
    bus_read(0, r);
    while (r[16] && n < 5000) begin
      @(negedge clk);
      bus_read(0, r);
      n++;
    end
  endtask

  function automatic logic [7:0] exp_byte(int i, int tx, logic [31:0] op, logic [31:0] dat);
    if (i >= tx) return 8'h00;
    if (i == 0) return op[7:0];
    if (i < 4) return op[31 - 8 * (i - 1) -: 8];
    if (i < 8) return dat[8 * (i - 4) +: 8];
    return 8'h00;
  endfunction

  // {tx[3:0], rx[3:0], opcode, data, flash reply}
  localparam int NV = 8;
  localparam logic [103:0] VEC [NV] = '{
    {4'd1,  4'd0, 32'h0000_0006, 32'h0000_0000, 32'h0000_0000},
    {4'd4,  4'd0, 32'h1234_56D8, 32'h0000_0000, 32'h0000_0000},
    {4'd8,  4'd0, 32'hABCD_EF02, 32'h4433_2211, 32'h0000_0000},
    {4'd1,  4'd1, 32'h0000_0005, 32'h0000_0000, 32'h5A00_0000},
    {4'd4,  4'd4, 32'h0000_0003, 32'h0000_0000, 32'hDEAD_BEEF},
    {4'd4,  4'd1, 32'h0000_00AB, 32'hFFFF_FFFF, 32'h1700_0000},
    {4'd10, 4'd0, 32'h0A0B_0C9F, 32'h0102_0304, 32'h0000_0000},
    {4'd2,  4'd3, 32'h00C0_FFEE, 32'h0000_0000, 32'h1122_3344}
  };

  task automatic run_cmd(input int tx, input int rx, input logic [31:0] op,
                         input logic [31:0] dat, input logic [31:0] resp);
    logic [31:0] r, expd;
    int f0;
    cur_tx = tx; cur_resp = resp;
    bus_write(4, op);
    bus_write(8, dat);
    f0 = ncs;
    bus_write(0, {24'h0, rx[3:0], tx[3:0]} | 32'h100);
    wait_idle();
    @(negedge clk);
    chk(ncs == f0 + 1, "R3 one chip-select assertion", ncs - f0, 1);
    chk(nbits == 8 * (tx + rx), "R6 sck pulse count", nbits, 8 * (tx + rx));
    chk(lead == 2 * SCK_HALF * 10, "R8 cs-to-first-sck time", 32'(lead), 2 * SCK_HALF * 10);
    for (int i = 0; i < tx; i++)
      chk(cap[i] == exp_byte(i, tx, op, dat), "R5 transmit byte", cap[i], exp_byte(i, tx, op, dat));
    for (int j = 0; j < rx; j++)
      chk(cap[tx + j] == 8'h00, "R7 mosi low in receive", cap[tx + j], 0);
    expd = dat;
    for (int j = 0; j < rx; j++) expd = {expd[23:0], resp[31 - 8 * j -: 8]};
    bus_read(8, r);
    chk(r == expd, "R7 receive data", r, expd);
    bus_read(0, r);
    chk(r == {24'h0, rx[3:0], tx[3:0]}, "R2 control readback", r, {24'h0, rx[3:0], tx[3:0]});
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bus_read(0, r); chk(r == 0, "R1 control reset", r, 0);
    bus_read(4, r); chk(r == 0, "R1 opcode reset", r, 0);
    bus_read(8, r); chk(r == 0, "R1 data reset", r, 0);
    chk(spi_cs_n == 1 && spi_sck == 0 && spi_mosi == 0, "R1 pins idle",
        {spi_cs_n, spi_sck, spi_mosi}, 3'b100);

    // R2 register map
    bus_write(4, 32'h5566_7788); bus_read(4, r); chk(r == 32'h5566_7788, "R2 opcode", r, 32'h5566_7788);
    bus_write(8, 32'h99AA_BBCC); bus_read(8, r); chk(r == 32'h99AA_BBCC, "R2 data", r, 32'h99AA_BBCC);
    bus_write(12, 32'hFFFF_FFFF); bus_read(12, r); chk(r == 0, "R2 unmapped offset", r, 0);
    bus_read(4, r); chk(r == 32'h5566_7788, "R2 unmapped write no effect", r, 32'h5566_7788);

    // R4 zero transmit count with start, also R2 bit behaviour
    f0 = ncs;
    bus_write(0, 32'hFFFF_FF00);
    repeat (20) @(negedge clk);
    bus_read(0, r);
    chk(r == 32'hFFFE_FE00, "R2 stored bits, start and busy read 0", r, 32'hFFFE_FE00);
    chk(ncs == f0 && spi_cs_n == 1, "R4 no chip select for zero count", ncs - f0, 0);

    // table-driven transactions (R3 R5 R6 R7 R8)
    for (int v = 0; v < NV; v++)
      run_cmd(int'(VEC[v][103:100]), int'(VEC[v][99:96]), VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);

    // R3 control write while busy is ignored
    cur_tx = 2; cur_resp = 0;
    bus_write(4, 32'h0000_1122);
    f0 = ncs;
    bus_write(0, 32'h0000_0102);
    repeat (10) @(negedge clk);
    bus_write(0, 32'h0000_0104);
    wait_idle();
    @(negedge clk);
    chk(nbits == 16, "R3 write while busy ignored (length)", nbits, 16);
    chk(ncs == f0 + 1, "R3 no restart while busy", ncs - f0, 1);
    bus_read(0, r); chk(r == 32'h0000_0002, "R3 control kept while busy", r, 2);

    // R9 start landing in the cycle after chip-select release
    cur_tx = 1;
    bus_write(4, 32'h0000_0006);
    bus_write(0, 32'h0000_0101);
    @(posedge spi_cs_n);
    f0 = ncs;
    @(negedge clk);
    bus_read(0, r);
    chk(r[16] == 1'b1, "R9 busy held one cycle after release", r[16], 1);
    bus_en = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'h0000_0103;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    bus_read(0, r);
    chk(r == 32'h0000_0001, "R9 control write in release cycle ignored", r, 1);
    repeat (20) @(negedge clk);
    chk(ncs == f0, "R9 no transaction from ignored start", ncs - f0, 0);

    // a start one cycle later runs normally
    run_cmd(3, 0, 32'h00A1_B2C3, 32'h0, 32'h0);

    finish_run();
  end
endmodule